// File: doc/BRIEF.md
# Double-Buffered Compare and Output Channel

This block is one channel of a timer's compare section. Software writes a compare value into a holding buffer, and that buffer can always be read back. The value that the timer count is actually compared against sits in a separate compare latch. The latch copies the buffer only when a selectable load event occurs. This allows a new threshold to be staged in advance and take effect at a clean point in the count period, such as the wrap to zero or the peak in up/down counting.

When the count equals the latch, the channel raises an equal signal and sets a sticky interrupt flag. A registered output pin is driven by one of eight modes:
- a direct software-controlled bit;
- three single-action modes (set, toggle, reset) triggered by this channel's match;
- four two-action modes, where this channel's match applies the first action and the period match of channel 0 applies the second.

The counter itself and any capture logic live outside the block. The count, the counting mode, the channel-0 latch value and the channel-0 equal signal arrive as plain inputs. The write port is a simple strobe that is always accepted and never back-pressures. There is no valid/ready stream at this block's edge.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset, the holding buffer (`rd_data`), the compare latch, `irq_flag` and `out_pin` are all 0. The load-select and output-mode inputs are expected to be 0 (immediate loading, software bit) after a system reset.
- R2: A clock edge with `wr_en` high stores `wr_data` in the holding buffer. `rd_data` shows it from the next cycle on. `rd_data` always returns the buffer, never the latch.
- R3: With `load_sel` = 00, an edge with `wr_en` high also copies `wr_data` into the compare latch on that same edge. With no write, the latch keeps its value.
- R4: With `load_sel` = 01, the latch takes the buffer value held before the edge, at every edge where `tmr_cnt` is 0. It holds otherwise, writes included.
- R5: With `load_sel` = 10, the latch loads from the buffer when `tmr_cnt` is 0. When `cnt_mode` = 10 (up/down), it also loads when `tmr_cnt` equals `ch0_latch`. `cnt_mode` 00 (up), 01 (continuous) and 11 load only at 0.
- R6: With `load_sel` = 11, the latch loads from the buffer at every edge where `tmr_cnt` equals the current latch value.
- R7: `equ` is combinationally high whenever `tmr_cnt` equals the compare latch. `irq_flag` is set on each edge where `equ` is high. It is cleared on an edge with `flag_clr` high and `equ` low; setting wins over clearing.
- R8: With `out_mode` = 000, `out_pin` takes `out_bit` on every edge.
- R9: Single-action modes act on each edge where `equ` is high and ignore `ch0_equ`: 001 sets the pin, 100 toggles it, 101 resets it.
- R10: Two-action modes apply a first action on an `equ` edge and a second action on a `ch0_equ` edge: 010 toggle then reset, 011 set then reset, 110 toggle then set, 111 reset then set. When both are high on one edge, the first action is applied and then the second, so a set or reset from `ch0_equ` decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_cnt | input | W | Current timer count |
| cnt_mode | input | 2 | Counting mode: 00 up, 01 continuous, 10 up/down, 11 treated as up |
| ch0_latch | input | W | Compare latch value of channel 0 (period) |
| ch0_equ | input | 1 | Equal signal of channel 0 |
| wr_en | input | 1 | Write strobe for the compare buffer |
| wr_data | input | W | Value written to the compare buffer |
| rd_data | output | W | Read-back of the compare buffer |
| load_sel | input | 2 | Latch load event select |
| out_mode | input | 3 | Output mode select |
| out_bit | input | 1 | Software output value for mode 000 |
| flag_clr | input | 1 | Clears the interrupt flag |
| equ | output | 1 | Count equals compare latch |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| out_pin | output | 1 | Channel output pin |

## Verification
The bench writes buffer values while the latch must hold, to catch a latch that follows writes in a deferred-load setting. Under R5 the load selection is run in up/down counting and also in up counting. An event decoder that ignores the counting mode would then reload at the peak where it must not, and the equal signal would shift. Edges where both `equ` and `ch0_equ` are high arise on small random periods. An output stage with the wrong action order would leave the pin set instead of reset, or the reverse. Clears that coincide with matches expose a flag whose clear overrides its set.

// File: rtl/cou_pkg.sv
package cou_pkg;

  typedef enum logic [1:0] {
    CNT_UP   = 2'b00,
    CNT_CONT = 2'b01,
    CNT_UPDN = 2'b10,
    CNT_RSV  = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    LD_ON_WRITE = 2'b00,
    LD_AT_ZERO  = 2'b01,
    LD_AT_EDGE  = 2'b10,
    LD_AT_MATCH = 2'b11
  } load_sel_e;

  typedef enum logic [2:0] {
    OM_SWBIT   = 3'd0,
    OM_SET     = 3'd1,
    OM_TGL_RST = 3'd2,
    OM_SET_RST = 3'd3,
    OM_TGL     = 3'd4,
    OM_RST     = 3'd5,
    OM_TGL_SET = 3'd6,
    OM_RST_SET = 3'd7
  } out_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } pin_act_e;

  // action taken on this channel's own match
  function automatic pin_act_e own_action(input out_mode_e m);
    case (m)
      OM_SET, OM_SET_RST:     own_action = ACT_SET;
      OM_TGL, OM_TGL_RST,
      OM_TGL_SET:             own_action = ACT_TGL;
      OM_RST, OM_RST_SET:     own_action = ACT_CLR;
      default:                own_action = ACT_NONE;
    endcase
  endfunction

  // action taken on the channel-0 period match
  function automatic pin_act_e per_action(input out_mode_e m);
    case (m)
      OM_TGL_RST, OM_SET_RST: per_action = ACT_CLR;
      OM_TGL_SET, OM_RST_SET: per_action = ACT_SET;
      default:                per_action = ACT_NONE;
    endcase
  endfunction

  function automatic logic apply_act(input pin_act_e a, input logic v);
    case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TGL: apply_act = ~v;
      default: apply_act = v;
    endcase
  endfunction

endpackage

// File: rtl/cou_load_evt.sv
module cou_load_evt
  import cou_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   load_sel,
  input  logic [1:0]   cnt_mode,
  input  logic [W-1:0] tmr_cnt,
  input  logic [W-1:0] ch0_latch,
  input  logic [W-1:0] latch_q,
  output logic         load_now
);
  logic at_zero;
  logic at_peak;
  logic at_self;
  logic updn;

  assign at_zero = (tmr_cnt == '0);
  assign at_peak = (tmr_cnt == ch0_latch);
  assign at_self = (tmr_cnt == latch_q);
  assign updn    = (cnt_mode_e'(cnt_mode) == CNT_UPDN);

  always_comb begin
    case (load_sel_e'(load_sel))
      LD_AT_ZERO:  load_now = at_zero;
      LD_AT_EDGE:  load_now = at_zero | (updn & at_peak);
      LD_AT_MATCH: load_now = at_self;
      default:     load_now = 1'b0;
    endcase
  end
endmodule

// File: rtl/cou_buffer.sv
module cou_buffer
  import cou_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   load_sel,
  input  logic         load_now,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] latch_q
);
  logic         imm_mode;
  logic         take_wr;
  logic         take_buf;
  logic [W-1:0] latch_d;

  assign imm_mode = (load_sel_e'(load_sel) == LD_ON_WRITE);
  assign take_wr  = imm_mode & wr_en;
  assign take_buf = ~imm_mode & load_now;

  always_comb begin
    latch_d = latch_q;
    if (take_wr)       latch_d = wr_data;
    else if (take_buf) latch_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      latch_q <= '0;
    end else begin
      if (wr_en) buf_q <= wr_data;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/cou_match.sv
module cou_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic [W-1:0] latch_q,
  input  logic         flag_clr,
  output logic         equ,
  output logic         irq_flag
);
  assign equ = (tmr_cnt == latch_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (equ)      irq_flag <= 1'b1;
    else if (flag_clr) irq_flag <= 1'b0;
  end
endmodule

// File: rtl/cou_outgen.sv
module cou_outgen
  import cou_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] out_mode,
  input  logic       out_bit,
  input  logic       equ,
  input  logic       ch0_equ,
  output logic       out_pin
);
  out_mode_e mode;
  pin_act_e  act_own;
  pin_act_e  act_per;
  logic      after_own;
  logic      pin_d;

  assign mode    = out_mode_e'(out_mode);
  assign act_own = equ     ? own_action(mode) : ACT_NONE;
  assign act_per = ch0_equ ? per_action(mode) : ACT_NONE;

  always_comb begin
    after_own = apply_act(act_own, out_pin);
    if (mode == OM_SWBIT) pin_d = out_bit;
    else                  pin_d = apply_act(act_per, after_own);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_pin <= 1'b0;
    else        out_pin <= pin_d;
  end
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic [1:0]   cnt_mode,
  input  logic [W-1:0] ch0_latch,
  input  logic         ch0_equ,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   load_sel,
  input  logic [2:0]   out_mode,
  input  logic         out_bit,
  input  logic         flag_clr,
  output logic         equ,
  output logic         irq_flag,
  output logic         out_pin
);
  logic [W-1:0] cmp_latch;
  logic         load_now;

  cou_load_evt #(.W(W)) u_evt (
    .load_sel  (load_sel),
    .cnt_mode  (cnt_mode),
    .tmr_cnt   (tmr_cnt),
    .ch0_latch (ch0_latch),
    .latch_q   (cmp_latch),
    .load_now  (load_now)
  );

  cou_buffer #(.W(W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .load_sel (load_sel),
    .load_now (load_now),
    .buf_q    (rd_data),
    .latch_q  (cmp_latch)
  );

  cou_match #(.W(W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_cnt  (tmr_cnt),
    .latch_q  (cmp_latch),
    .flag_clr (flag_clr),
    .equ      (equ),
    .irq_flag (irq_flag)
  );

  cou_outgen u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_mode (out_mode),
    .out_bit  (out_bit),
    .equ      (equ),
    .ch0_equ  (ch0_equ),
    .out_pin  (out_pin)
  );
endmodule

// File: rtl/cou_checker.sv
module cou_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [1:0]   load_sel,
  input logic [W-1:0] tmr_cnt,
  input logic [2:0]   out_mode,
  input logic         out_bit,
  input logic         ch0_equ,
  input logic         equ,
  input logic         irq_flag,
  input logic         out_pin,
  input logic [W-1:0] cmp_latch
);
  a_r2_buffer_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  a_r3_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && load_sel == 2'b00) |=> cmp_latch == $past(wr_data));

  a_r4_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel == 2'b01 && tmr_cnt == '0) |=> cmp_latch == $past(rd_data));

  a_r4_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel == 2'b01 && tmr_cnt != '0) |=> $stable(cmp_latch));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    equ |=> irq_flag);

  a_r8_software_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd0) |=> out_pin == $past(out_bit));

  a_r9_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd1 && equ) |=> out_pin);

  a_r9_reset_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd5 && equ) |=> !out_pin);

  a_r10_period_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd3 && ch0_equ) |=> !out_pin);

  a_r10_period_set: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd7 && ch0_equ) |=> out_pin);
endmodule

bind cmp_out_unit cou_checker #(.W(W)) u_chk (.*);

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tmr_cnt = '0;
  logic [1:0]   cnt_mode = '0;
  logic [W-1:0] ch0_latch = '0;
  logic         ch0_equ = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [1:0]   load_sel = '0;
  logic [2:0]   out_mode = '0;
  logic         out_bit = 1'b0;
  logic         flag_clr = 1'b0;
  logic         equ;
  logic         irq_flag;
  logic         out_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [W-1:0] m_buf, m_latch;
  logic         m_flag, m_pin;
  logic         dir_up;

  always #10 clk = ~clk;

  cmp_out_unit #(.W(W)) u_cmp_out_unit (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .cnt_mode(cnt_mode),
    .ch0_latch(ch0_latch), .ch0_equ(ch0_equ), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .load_sel(load_sel), .out_mode(out_mode), .out_bit(out_bit),
    .flag_clr(flag_clr), .equ(equ), .irq_flag(irq_flag), .out_pin(out_pin)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic do_act(input int a, input logic v);
    case (a)
      1: return 1'b1;
      2: return 1'b0;
      3: return ~v;
      default: return v;
    endcase
  endfunction

  // R9/R10 action tables: 0 none, 1 set, 2 reset, 3 toggle
  function automatic int first_act(input logic [2:0] m);
    case (m)
      3'd1, 3'd3: return 1;
      3'd2, 3'd4, 3'd6: return 3;
      3'd5, 3'd7: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int second_act(input logic [2:0] m);
    case (m)
      3'd2, 3'd3: return 2;
      3'd6, 3'd7: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic next_pin(input logic [2:0] m, input logic p,
                                    input logic ob, input logic e, input logic e0);
    logic v;
    if (m == 3'd0) return ob;
    v = e ? do_act(first_act(m), p) : p;
    return e0 ? do_act(second_act(m), v) : v;
  endfunction

  function automatic logic load_event(input logic [1:0] sel, input logic [1:0] cm,
                                      input logic [W-1:0] c, input logic [W-1:0] per,
                                      input logic [W-1:0] lat);
    case (sel)
      2'b01: return c == 0;
      2'b10: return (c == 0) || (cm == 2'b10 && c == per);
      2'b11: return c == lat;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string load_tag(input logic [1:0] sel);
    case (sel)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string pin_tag(input logic [2:0] m);
    if (m == 3'd0) return "R8";
    if (m == 3'd1 || m == 3'd4 || m == 3'd5) return "R9";
    return "R10";
  endfunction

  // one clock cycle: inputs already driven
  task automatic cycle();
    logic         e, nf, np;
    logic [W-1:0] nb, nl;
    ch0_equ = (tmr_cnt == ch0_latch);
    #2;
    e = (tmr_cnt == m_latch);
    check(equ == e, load_tag(load_sel), "equ", equ, e);
    nb = wr_en ? wr_data : m_buf;
    if (load_sel == 2'b00) nl = wr_en ? wr_data : m_latch;
    else nl = load_event(load_sel, cnt_mode, tmr_cnt, ch0_latch, m_latch) ? m_buf : m_latch;
    nf = e ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    np = next_pin(out_mode, m_pin, out_bit, e, ch0_equ);
    @(posedge clk);
    #1;
    m_buf = nb; m_latch = nl; m_flag = nf; m_pin = np;
    check(rd_data == m_buf, "R2", "rd_data", rd_data, m_buf);
    check(irq_flag == m_flag, "R7", "irq_flag", irq_flag, m_flag);
    check(out_pin == m_pin, pin_tag(out_mode), "out_pin", out_pin, m_pin);
  endtask

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic [1:0] cm,
                                            input logic [W-1:0] per);
    if (cm == 2'b10) begin
      if (dir_up) begin
        if (c >= per) begin dir_up = 1'b0; return per - 1; end
        return c + 1;
      end else begin
        if (c == 0) begin dir_up = 1'b1; return 1; end
        return c - 1;
      end
    end
    return (c >= per) ? '0 : c + 1;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    m_buf = '0; m_latch = '0; m_flag = 1'b0; m_pin = 1'b0; dir_up = 1'b1;
    tmr_cnt = 16'd5; ch0_latch = 16'd9;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(rd_data == 0, "R1", "rd_data", rd_data, 0);
    check(irq_flag == 0, "R1", "irq_flag", irq_flag, 0);
    check(out_pin == 0, "R1", "out_pin", out_pin, 0);
    check(equ == 0, "R1", "equ at count 5", equ, 0);
    tmr_cnt = 16'd0; #1;
    check(equ == 1, "R1", "latch zero, equ at count 0", equ, 1);
    rst_n = 1'b1;

    // directed R4: write deferred, latch holds until count 0
    load_sel = 2'b01; tmr_cnt = 16'd3; wr_en = 1'b1; wr_data = 16'd4;
    cycle();
    wr_en = 1'b0; tmr_cnt = 16'd4; cycle();   // latch still 0: no equ
    tmr_cnt = 16'd0; cycle();                 // load happens here
    tmr_cnt = 16'd4; cycle();                 // equ now

    // directed R5: up/down peak load vs up counting
    load_sel = 2'b10; ch0_latch = 16'd6; cnt_mode = 2'b00;
    wr_en = 1'b1; wr_data = 16'd2; tmr_cnt = 16'd6; cycle();
    wr_en = 1'b0; cycle();                    // up mode: no load at peak
    tmr_cnt = 16'd2; cycle();
    cnt_mode = 2'b10; tmr_cnt = 16'd6; cycle(); // up/down: load at peak
    tmr_cnt = 16'd2; cycle();

    // directed R10: both matches on one edge, channel-0 action decides
    load_sel = 2'b00; wr_en = 1'b1; wr_data = 16'd6; tmr_cnt = 16'd1; cycle();
    wr_en = 1'b0;
    out_mode = 3'd6; tmr_cnt = 16'd6; cycle();
    out_mode = 3'd2; cycle();
    out_mode = 3'd7; cycle();

    // constrained random segments
    for (int seg = 0; seg < 60; seg++) begin
      cnt_mode = 2'($urandom_range(0, 3));
      load_sel = 2'($urandom_range(0, 3));
      out_mode = 3'($urandom_range(0, 7));
      ch0_latch = 16'($urandom_range(2, 9));
      tmr_cnt = '0; dir_up = 1'b1;
      for (int k = 0; k < 50; k++) begin
        wr_en    = ($urandom_range(0, 7) == 0);
        wr_data  = 16'($urandom_range(0, 10));
        flag_clr = ($urandom_range(0, 3) == 0);
        out_bit  = 1'($urandom_range(0, 1));
        cycle();
        tmr_cnt = next_cnt(tmr_cnt, cnt_mode, ch0_latch);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule